// File: doc/BRIEF.md
# Address Translation Cache with Hardware Page-Table Walker

This block translates virtual addresses into physical addresses for a processor load/store path. It keeps a small, fully associative set of recent translations, each tagged with the virtual page number and with an address-space identifier that names the running process. Because entries carry that identifier, switching processes needs no invalidation. A lookup that matches a usable entry produces the physical address combinationally in the same cycle. The physical address is the cached physical page number placed above the untouched page offset.

When no usable entry exists, an internal state machine fetches one page-table entry from a flat, single-level table in memory. The entry's address is a base register plus the virtual page number times the entry size. A fetched entry that is not valid ends the walk with a page-fault pulse and installs nothing. A valid entry is installed. If the access is permitted and the entry's referenced bit (or, for a write, its modified bit) is still clear, the walker first writes the updated entry back to memory. A hit that breaks the page's permissions raises a protection fault instead of a translation.

The requester holds its lookup inputs steady until it sees a hit, a protection fault or a page fault. Two invalidation controls are provided: one clears every entry, and the other clears the entries of one address space.

Top module: `pgx_tlb`

## Requirements
- R1: A lookup whose virtual page number and address-space number match a valid entry, whose permissions allow it, and which is a read or a write to an entry already marked modified, raises `lk_hit` in the same cycle with `lk_paddr` = {entry page number, `lk_vaddr[11:0]`} and makes no memory request.
- R2: An entry matches only a lookup carrying the same address-space number. The same virtual page under another number misses and is walked, and the first entry stays usable.
- R3: On a miss the walker issues one read at `pt_base + vpn*4` and installs the returned entry. The entry layout is: bit 0 valid, bit 1 writable, bit 2 user-accessible, bit 3 referenced, bit 4 modified, bits [31:12] physical page number.
- R4: If the fetched entry has bit 0 clear, `lk_page_fault` is high for exactly one cycle after the read completes, nothing is installed, and a repeat lookup walks again.
- R5: When the access is permitted and the fetched entry has its referenced bit clear, the walker writes the entry back to the same address with bit 3 set (and bit 4 set for a write) before installing it. Entries whose needed bits are already set cause no write.
- R6: A write that hits an entry not yet marked modified triggers a new walk. That walk writes the entry back with bit 4 set and updates the same slot, after which writes hit directly.
- R7: A write to a page with bit 1 clear, or a user lookup (`lk_user`=1) to a page with bit 2 clear, raises `lk_prot_fault` instead of `lk_hit` and makes no memory request. This also applies right after such an entry is walked in.
- R8: An install fills the lowest-numbered invalid slot. When all slots are valid, it replaces the slot at a round-robin pointer that starts at 0 and advances by one per such replacement.
- R9: `flush_all` invalidates every entry, so the next lookup of any page walks.
- R10: `flush_asn_en` invalidates only the entries whose address-space number equals `flush_asn_id`.
- R11: After reset all entries are invalid, and `lk_hit`, `lk_page_fault` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request, held until an outcome |
| lk_vaddr | input | 32 | Virtual address |
| lk_asn | input | 8 | Address-space number of the requester |
| lk_write | input | 1 | Lookup is for a write |
| lk_user | input | 1 | Lookup is from user mode |
| lk_hit | output | 1 | Translation available this cycle |
| lk_paddr | output | 32 | Physical address (meaningful with lk_hit) |
| lk_prot_fault | output | 1 | Permission violation on a matching entry |
| lk_page_fault | output | 1 | One-cycle pulse: fetched entry invalid |
| walk_busy | output | 1 | Walker is active |
| pt_base | input | 32 | Page-table base address |
| flush_all | input | 1 | Invalidate all entries |
| flush_asn_en | input | 1 | Invalidate entries of one address space |
| flush_asn_id | input | 8 | Address space to invalidate |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the table entry |
| mem_wdata | output | 32 | Updated table entry for writes |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 32 | Table entry returned on a read ack |

## Verification
The properties assume that memory raises `mem_ack` only while `mem_req` is high. They also assume that the requester keeps the lookup inputs and `pt_base` steady while a walk is running, and that it does not pulse a flush in the cycle a walk installs. The bench's memory model acks one cycle after it sees a request and drops the ack at once. The bench holds each lookup until an outcome appears, then releases it. Flushes are issued only between lookups, while the walker is idle.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    typedef enum logic [1:0] {
        WK_IDLE   = 2'd0,
        WK_READ   = 2'd1,
        WK_UPDATE = 2'd2,
        WK_FAULT  = 2'd3
    } walk_state_e;

    // Flag positions inside a page-table entry
    localparam int BIT_VALID = 0;
    localparam int BIT_WRITE = 1;
    localparam int BIT_USER  = 2;
    localparam int BIT_REF   = 3;
    localparam int BIT_MOD   = 4;

endpackage

// File: rtl/pgx_match.sv
module pgx_match #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int ASN_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]       valid_i,
    input  logic [ENTRIES*VPN_W-1:0] vpn_flat_i,
    input  logic [ENTRIES*ASN_W-1:0] asn_flat_i,
    input  logic [VPN_W-1:0]         vpn_i,
    input  logic [ASN_W-1:0]         asn_i,
    output logic                     hit_o,
    output logic [IDX_W-1:0]         idx_o
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = valid_i[g]
                     && (vpn_flat_i[g*VPN_W +: VPN_W] == vpn_i)
                     && (asn_flat_i[g*ASN_W +: ASN_W] == asn_i);
    end

    assign hit_o = |eq;

    // At most one slot matches, so OR-ing indices encodes it
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (eq[i]) idx_o = idx_o | IDX_W'(i);
        end
    end
endmodule

// File: rtl/pgx_victim.sv
module pgx_victim #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [IDX_W-1:0]   rr_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic               full_o
);
    always_comb begin
        full_o = &valid_i;
        idx_o  = rr_i;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/pgx_walker.sv
module pgx_walker
    import pgx_pkg::*;
#(
    parameter int VPN_W     = 20,
    parameter int ASN_W     = 8,
    parameter int PA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int PTE_BYTES = 4,
    localparam int PPN_W    = PA_W - OFF_W,
    localparam int SH       = $clog2(PTE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [VPN_W-1:0] vpn_i,
    input  logic [ASN_W-1:0] asn_i,
    input  logic             wr_i,
    input  logic             usr_i,
    input  logic [PA_W-1:0]  ptbase_i,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [PA_W-1:0]  mem_addr_o,
    output logic [PA_W-1:0]  mem_wdata_o,
    input  logic             mem_ack_i,
    input  logic [PA_W-1:0]  mem_rdata_i,
    output logic             inst_o,
    output logic [VPN_W-1:0] inst_vpn_o,
    output logic [ASN_W-1:0] inst_asn_o,
    output logic [PPN_W-1:0] inst_ppn_o,
    output logic             inst_wr_o,
    output logic             inst_usr_o,
    output logic             inst_dirty_o,
    output logic             page_fault_o,
    output logic             busy_o
);
    typedef struct packed {
        walk_state_e      st;
        logic [VPN_W-1:0] vpn;
        logic [ASN_W-1:0] asn;
        logic             wr;
        logic             usr;
        logic [PA_W-1:0]  pte;
    } wk_t;

    wk_t wk_d, wk_q;
    logic [PA_W-1:0] src;
    logic            allowed;
    logic [PA_W-1:0] upd;

    always_comb begin
        wk_d         = wk_q;
        mem_req_o    = 1'b0;
        mem_we_o     = 1'b0;
        mem_addr_o   = ptbase_i + (PA_W'(wk_q.vpn) << SH);
        mem_wdata_o  = wk_q.pte;
        inst_o       = 1'b0;
        page_fault_o = 1'b0;
        src          = mem_rdata_i;
        allowed      = !(wk_q.wr && !mem_rdata_i[BIT_WRITE])
                    && !(wk_q.usr && !mem_rdata_i[BIT_USER]);
        upd          = mem_rdata_i;
        upd[BIT_REF] = 1'b1;
        if (wk_q.wr) upd[BIT_MOD] = 1'b1;

        unique case (wk_q.st)
            WK_IDLE: begin
                if (start_i) begin
                    wk_d.st  = WK_READ;
                    wk_d.vpn = vpn_i;
                    wk_d.asn = asn_i;
                    wk_d.wr  = wr_i;
                    wk_d.usr = usr_i;
                end
            end
            WK_READ: begin
                mem_req_o = 1'b1;
                if (mem_ack_i) begin
                    if (!mem_rdata_i[BIT_VALID]) begin
                        wk_d.st = WK_FAULT;
                    end else if (allowed && (upd != mem_rdata_i)) begin
                        wk_d.pte = upd;
                        wk_d.st  = WK_UPDATE;
                    end else begin
                        inst_o  = 1'b1;
                        wk_d.st = WK_IDLE;
                    end
                end
            end
            WK_UPDATE: begin
                mem_req_o = 1'b1;
                mem_we_o  = 1'b1;
                src       = wk_q.pte;
                if (mem_ack_i) begin
                    inst_o  = 1'b1;
                    wk_d.st = WK_IDLE;
                end
            end
            WK_FAULT: begin
                page_fault_o = 1'b1;
                wk_d.st      = WK_IDLE;
            end
            default: wk_d.st = WK_IDLE;
        endcase
    end

    assign inst_vpn_o   = wk_q.vpn;
    assign inst_asn_o   = wk_q.asn;
    assign inst_ppn_o   = src[PA_W-1:OFF_W];
    assign inst_wr_o    = src[BIT_WRITE];
    assign inst_usr_o   = src[BIT_USER];
    assign inst_dirty_o = src[BIT_MOD];
    assign busy_o       = (wk_q.st != WK_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) wk_q <= '0;
        else        wk_q <= wk_d;
    end
endmodule

// File: rtl/pgx_tlb.sv
module pgx_tlb #(
    parameter int ENTRIES   = 32,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int OFF_W     = 12,
    parameter int ASN_W     = 8,
    parameter int PTE_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [ASN_W-1:0] lk_asn,
    input  logic             lk_write,
    input  logic             lk_user,
    output logic             lk_hit,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             lk_prot_fault,
    output logic             lk_page_fault,
    output logic             walk_busy,
    input  logic [PA_W-1:0]  pt_base,
    input  logic             flush_all,
    input  logic             flush_asn_en,
    input  logic [ASN_W-1:0] flush_asn_id,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PA_W-1:0]  mem_addr,
    output logic [PA_W-1:0]  mem_wdata,
    input  logic             mem_ack,
    input  logic [PA_W-1:0]  mem_rdata
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic             v;
        logic [VPN_W-1:0] vpn;
        logic [ASN_W-1:0] asn;
        logic [PPN_W-1:0] ppn;
        logic             wr;
        logic             usr;
        logic             dirty;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
        logic [IDX_W-1:0]     rr;
        logic                 tgt_hit;
        logic [IDX_W-1:0]     tgt_idx;
    } regs_t;

    regs_t r_d, r_q;

    logic [ENTRIES-1:0]       v_vec;
    logic [ENTRIES*VPN_W-1:0] vpn_flat;
    logic [ENTRIES*ASN_W-1:0] asn_flat;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign v_vec[g]                    = r_q.ent[g].v;
        assign vpn_flat[g*VPN_W +: VPN_W]  = r_q.ent[g].vpn;
        assign asn_flat[g*ASN_W +: ASN_W]  = r_q.ent[g].asn;
    end

    logic             m_hit;
    logic [IDX_W-1:0] m_idx;
    logic [VPN_W-1:0] lk_vpn;

    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

    pgx_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_match (
        .valid_i    (v_vec),
        .vpn_flat_i (vpn_flat),
        .asn_flat_i (asn_flat),
        .vpn_i      (lk_vpn),
        .asn_i      (lk_asn),
        .hit_o      (m_hit),
        .idx_o      (m_idx)
    );

    logic [IDX_W-1:0] vic_idx;
    logic             vic_full;

    pgx_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid_i (v_vec),
        .rr_i    (r_q.rr),
        .idx_o   (vic_idx),
        .full_o  (vic_full)
    );

    entry_t sel;
    logic   perm_bad;
    logic   clean_wr;
    logic   start;

    assign sel      = r_q.ent[m_idx];
    assign perm_bad = (lk_write && !sel.wr) || (lk_user && !sel.usr);
    assign clean_wr = lk_write && !sel.dirty;

    assign lk_hit        = lk_valid && m_hit && !perm_bad && !clean_wr;
    assign lk_prot_fault = lk_valid && m_hit && perm_bad;
    assign lk_paddr      = {sel.ppn, lk_vaddr[OFF_W-1:0]};
    assign start         = lk_valid && !walk_busy && !flush_all && !flush_asn_en
                        && (!m_hit || (!perm_bad && clean_wr));

    logic             inst;
    logic [VPN_W-1:0] inst_vpn;
    logic [ASN_W-1:0] inst_asn;
    logic [PPN_W-1:0] inst_ppn;
    logic             inst_wr;
    logic             inst_usr;
    logic             inst_dirty;

    pgx_walker #(
        .VPN_W(VPN_W), .ASN_W(ASN_W), .PA_W(PA_W), .OFF_W(OFF_W), .PTE_BYTES(PTE_BYTES)
    ) u_walker (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .vpn_i        (lk_vpn),
        .asn_i        (lk_asn),
        .wr_i         (lk_write),
        .usr_i        (lk_user),
        .ptbase_i     (pt_base),
        .mem_req_o    (mem_req),
        .mem_we_o     (mem_we),
        .mem_addr_o   (mem_addr),
        .mem_wdata_o  (mem_wdata),
        .mem_ack_i    (mem_ack),
        .mem_rdata_i  (mem_rdata),
        .inst_o       (inst),
        .inst_vpn_o   (inst_vpn),
        .inst_asn_o   (inst_asn),
        .inst_ppn_o   (inst_ppn),
        .inst_wr_o    (inst_wr),
        .inst_usr_o   (inst_usr),
        .inst_dirty_o (inst_dirty),
        .page_fault_o (lk_page_fault),
        .busy_o       (walk_busy)
    );

    logic [IDX_W-1:0] ins_idx;

    always_comb begin
        r_d     = r_q;
        ins_idx = r_q.tgt_hit ? r_q.tgt_idx : vic_idx;

        if (start) begin
            r_d.tgt_hit = m_hit;
            r_d.tgt_idx = m_idx;
        end

        if (inst) begin
            r_d.ent[ins_idx].v     = 1'b1;
            r_d.ent[ins_idx].vpn   = inst_vpn;
            r_d.ent[ins_idx].asn   = inst_asn;
            r_d.ent[ins_idx].ppn   = inst_ppn;
            r_d.ent[ins_idx].wr    = inst_wr;
            r_d.ent[ins_idx].usr   = inst_usr;
            r_d.ent[ins_idx].dirty = inst_dirty;
            if (!r_q.tgt_hit && vic_full) begin
                r_d.rr = (r_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : r_q.rr + 1'b1;
            end
        end

        // Invalidation wins over a same-cycle install
        for (int i = 0; i < ENTRIES; i++) begin
            if (flush_all || (flush_asn_en && r_d.ent[i].asn == flush_asn_id)) begin
                r_d.ent[i].v = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/pgx_tlb_chk.sv
module pgx_tlb_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_hit,
    input logic            lk_prot_fault,
    input logic            lk_page_fault,
    input logic            flush_all,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_ack,
    input logic [PA_W-1:0] mem_addr,
    input logic [PA_W-1:0] mem_wdata
);
    // R7: an outcome is either a translation or a protection fault
    a_r7_hit_or_prot: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_prot_fault));

    // R4: page fault is a single-cycle pulse
    a_r4_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        lk_page_fault |=> !lk_page_fault);

    // R4: a page fault follows a completed table read
    a_r4_fault_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        lk_page_fault |-> $past(mem_req && !mem_we && mem_ack));

    // R3: a pending request keeps its address and kind
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5: every write-back carries valid and referenced bits
    a_r5_wb_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[0] && mem_wdata[3]));

    // R9: nothing translates right after a full flush
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !lk_hit);

    // R11: no walk begins in the cycle after reset
    a_r11_quiet_reset: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !lk_page_fault));
endmodule

bind pgx_tlb pgx_tlb_chk #(.PA_W(PA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_hit        (lk_hit),
    .lk_prot_fault (lk_prot_fault),
    .lk_page_fault (lk_page_fault),
    .flush_all     (flush_all),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_ack       (mem_ack),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata)
);

// File: tb/pgx_tlb_test.sv
module pgx_tlb_test;
    localparam logic [31:0] PTB = 32'h0010_0000;
    localparam int OK = 0, PROT = 1, PF = 2, NONE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asn = '0;
    logic        lk_write = 1'b0;
    logic        lk_user = 1'b0;
    logic        lk_hit, lk_prot_fault, lk_page_fault, walk_busy;
    logic [31:0] lk_paddr;
    logic        flush_all = 1'b0;
    logic        flush_asn_en = 1'b0;
    logic [7:0]  flush_asn_id = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2 clk = ~clk;

    pgx_tlb uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_asn(lk_asn), .lk_write(lk_write), .lk_user(lk_user), .lk_hit(lk_hit),
        .lk_paddr(lk_paddr), .lk_prot_fault(lk_prot_fault), .lk_page_fault(lk_page_fault),
        .walk_busy(walk_busy), .pt_base(PTB), .flush_all(flush_all),
        .flush_asn_en(flush_asn_en), .flush_asn_id(flush_asn_id), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    logic [31:0] pt [0:63];
    int          nrd = 0, nwr = 0, mi;
    logic [31:0] last_raddr = '0, last_waddr = '0, last_wdata = '0;
    int          nchk = 0, nerr = 0;

    // Memory model: acks one cycle after it sees a request
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
        end else if (mem_req && !mem_ack) begin
            mi = int'((mem_addr - PTB) >> 2) & 63;
            mem_ack = 1'b1;
            if (mem_we) begin
                pt[mi] = mem_wdata; nwr++; last_waddr = mem_addr; last_wdata = mem_wdata;
            end else begin
                mem_rdata = pt[mi]; nrd++; last_raddr = mem_addr;
            end
        end else begin
            mem_ack = 1'b0;
        end
    end

    function automatic logic [31:0] mk(input logic [19:0] ppn, input logic [4:0] fl);
        return {ppn, 7'b0, fl};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] asn, input logic wr,
                        input logic usr, output int res, output logic [31:0] pa);
        lk_vaddr = va; lk_asn = asn; lk_write = wr; lk_user = usr; lk_valid = 1'b1;
        res = NONE; pa = '0;
        for (int c = 0; c < 40; c++) begin
            #1;
            if (lk_hit) begin res = OK; pa = lk_paddr; break; end
            if (lk_prot_fault) begin res = PROT; break; end
            if (lk_page_fault) begin res = PF; break; end
            @(negedge clk);
        end
        lk_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    task automatic t_reset();
        #1;
        chk("R11 hit low", {31'b0, lk_hit}, 0);
        chk("R11 req low", {31'b0, mem_req}, 0);
        chk("R11 fault low", {31'b0, lk_page_fault}, 0);
    endtask

    task automatic t_miss_hit();
        int r; logic [31:0] pa; int rd0;
        pt[5] = mk(20'h00ABC, 5'h1F);
        rd0 = nrd;
        look(32'h0000_5123, 8'd3, 1'b0, 1'b1, r, pa);
        chk("R3 walk outcome", r, OK);
        chk("R1 paddr", pa, 32'h00AB_C123);
        chk("R3 one read", nrd - rd0, 1);
        chk("R3 read addr", last_raddr, PTB + 32'd20);
        chk("R5 no write when set", nwr, 0);
        look(32'h0000_5FF0, 8'd3, 1'b0, 1'b1, r, pa);
        chk("R1 hit paddr", pa, 32'h00AB_CFF0);
        chk("R1 no read on hit", nrd - rd0, 1);
    endtask

    task automatic t_asn();
        int r; logic [31:0] pa; int rd0;
        rd0 = nrd;
        look(32'h0000_5010, 8'd4, 1'b0, 1'b1, r, pa);
        chk("R2 other asn walks", nrd - rd0, 1);
        look(32'h0000_5010, 8'd3, 1'b0, 1'b1, r, pa);
        chk("R2 first asn still hits", nrd - rd0, 1);
        chk("R2 paddr", pa, 32'h00AB_C010);
    endtask

    task automatic t_ref_mod();
        int r; logic [31:0] pa; int rd0, wr0;
        pt[6] = mk(20'h00123, 5'h07);
        rd0 = nrd; wr0 = nwr;
        look(32'h0000_6ABC, 8'd3, 1'b0, 1'b1, r, pa);
        chk("R5 read hits after update", pa, 32'h0012_3ABC);
        chk("R5 one write", nwr - wr0, 1);
        chk("R5 ref set", last_wdata, 32'h0012_300F);
        chk("R5 write addr", last_waddr, PTB + 32'd24);
        look(32'h0000_6004, 8'd3, 1'b1, 1'b1, r, pa);
        chk("R6 write outcome", r, OK);
        chk("R6 rewalk read", nrd - rd0, 2);
        chk("R6 mod set", last_wdata, 32'h0012_301F);
        look(32'h0000_6008, 8'd3, 1'b1, 1'b1, r, pa);
        chk("R6 later write hits", nrd - rd0, 2);
        chk("R6 no extra write", nwr - wr0, 2);
    endtask

    task automatic t_page_fault();
        int r; logic [31:0] pa; int rd0, wr0;
        pt[7] = '0;
        rd0 = nrd; wr0 = nwr;
        look(32'h0000_7000, 8'd3, 1'b0, 1'b0, r, pa);
        chk("R4 page fault", r, PF);
        chk("R4 no write", nwr - wr0, 0);
        #1;
        chk("R4 pulse over", {31'b0, lk_page_fault}, 0);
        pt[7] = mk(20'h00777, 5'h1F);
        look(32'h0000_7000, 8'd3, 1'b0, 1'b0, r, pa);
        chk("R4 not installed", nrd - rd0, 2);
        chk("R4 later ok", pa, 32'h0077_7000);
    endtask

    task automatic t_prot();
        int r; logic [31:0] pa; int rd0, wr0;
        pt[8] = mk(20'h00345, 5'h0D);
        pt[9] = mk(20'h00678, 5'h1B);
        look(32'h0000_8010, 8'd3, 1'b0, 1'b1, r, pa);
        chk("R7 readonly read ok", pa, 32'h0034_5010);
        rd0 = nrd; wr0 = nwr;
        look(32'h0000_8010, 8'd3, 1'b1, 1'b1, r, pa);
        chk("R7 write to readonly", r, PROT);
        chk("R7 no memory", (nrd - rd0) + (nwr - wr0), 0);
        look(32'h0000_9020, 8'd3, 1'b0, 1'b1, r, pa);
        chk("R7 user on kernel page", r, PROT);
        chk("R7 walked no update", nwr - wr0, 0);
        look(32'h0000_9020, 8'd3, 1'b0, 1'b0, r, pa);
        chk("R7 kernel ok", pa, 32'h0067_8020);
        chk("R7 one walk only", nrd - rd0, 1);
    endtask

    task automatic t_flush_asn();
        int r; logic [31:0] pa; int rd0;
        flush_asn_id = 8'd4; flush_asn_en = 1'b1;
        @(negedge clk);
        flush_asn_en = 1'b0;
        rd0 = nrd;
        look(32'h0000_5000, 8'd3, 1'b0, 1'b1, r, pa);
        chk("R10 other asn kept", nrd - rd0, 0);
        look(32'h0000_5000, 8'd4, 1'b0, 1'b1, r, pa);
        chk("R10 flushed asn walks", nrd - rd0, 1);
    endtask

    task automatic t_flush_all();
        int r; logic [31:0] pa; int rd0;
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        rd0 = nrd;
        look(32'h0000_5000, 8'd3, 1'b0, 1'b1, r, pa);
        chk("R9 walk after flush", nrd - rd0, 1);
    endtask

    task automatic t_replace();
        int r; logic [31:0] pa; int rd0;
        for (int v = 16; v < 50; v++) pt[v] = mk(20'h00200 + 20'(v), 5'h1F);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        for (int v = 16; v < 48; v++) look(32'(v) << 12, 8'd1, 1'b0, 1'b0, r, pa);
        rd0 = nrd;
        look(32'h0003_0040, 8'd1, 1'b0, 1'b0, r, pa);
        chk("R8 full install", pa, 32'h0023_0040);
        look(32'h0001_1000, 8'd1, 1'b0, 1'b0, r, pa);
        chk("R8 slot1 kept", nrd - rd0, 1);
        look(32'h0001_0000, 8'd1, 1'b0, 1'b0, r, pa);
        chk("R8 slot0 evicted", nrd - rd0, 2);
        look(32'h0001_1000, 8'd1, 1'b0, 1'b0, r, pa);
        chk("R8 pointer advanced", nrd - rd0, 3);
        look(32'h0001_3000, 8'd1, 1'b0, 1'b0, r, pa);
        chk("R8 slot3 kept", nrd - rd0, 3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) pt[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        @(negedge clk);
        t_miss_hit();
        t_asn();
        t_ref_mod();
        t_page_fault();
        t_prot();
        t_flush_asn();
        t_flush_all();
        t_replace();
        finish_run();
    end
endmodule